// File: doc/BRIEF.md
# Supply Voltage Threshold Monitor

This block is the digital side of a programmable supply-voltage detector. Every clock it receives a 12-bit supply reading in millivolts from a converter. It compares the reading against one of eight falling trip levels chosen by a 3-bit select. A fixed hysteresis band separates the falling trip level from the level the supply must reach to count as recovered. The result passes through a synchroniser and drives a detector line, which also serves as the read-only status bit: 1 means the supply is below the selected threshold.

Each change of the detector line produces a one-cycle edge pulse toward an external interrupt controller. That controller is represented here by two edge-enable inputs and a sticky pending flag. Software writes 1 to `pend_clr` to clear the flag. An enable bit gates the whole function, and the detector line stays inactive while the enable is clear.

When the select changes while the block is enabled, the comparator judges the next reading against the new falling level from scratch. Any edge pulse that would fall in the cycle of that write is held back by one cycle.

Top module: `svm_monitor`

## Requirements
- R1: After synchronous reset, `det_below`, `irq_pend`, `edge_rise`, `edge_fall` and `ctl_en` are 0, and `ctl_sel` is 0.
- R2: A cycle with `ctl_wr` = 1 loads `ctl_en_wd` and `ctl_sel_wd`, and both appear on `ctl_en` and `ctl_sel` after that clock edge.
- R3: With the block enabled and `det_below` = 0, a reading below the falling level of the selected entry (`BASE_MV` + select × `STEP_MV`, 2700 + 150 × select mV by default) sets `det_below` after the third rising edge that samples it.
- R4: Once `det_below` = 1, it stays 1 while the reading is below the falling level + `HYST_MV` (200 mV by default). It returns to 0 three edges after the reading reaches that level.
- R5: While the enable is clear, `det_below` is 0 and no edge pulse or pending flag is produced. Clearing the enable while `det_below` = 1 drops the line one edge later without a falling pulse.
- R6: After a write that changes the select, the next comparison uses only the new falling level, with no hysteresis memory from the old entry.
- R7: `edge_rise` is high for exactly the first cycle in which `det_below` reads 1 after having read 0. `edge_fall` is high for exactly the first cycle in which `det_below` reads 0 after having read 1.
- R8: In a cycle where an enabled block receives a write that changes the select, both edge outputs are 0. An edge that would have shown then appears in the following cycle.
- R9: `irq_pend` is set at the edge after an `edge_rise` pulse when `trig_rise_en` = 1, and after an `edge_fall` pulse when `trig_fall_en` = 1. A pulse whose trigger enable is 0 leaves the flag as it is.
- R10: `pend_clr` = 1 clears `irq_pend` at the next edge. If a set condition arrives in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| volt_mv | input | 12 | Supply reading in millivolts |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en_wd | input | 1 | Enable value to write |
| ctl_sel_wd | input | 3 | Threshold select value to write |
| ctl_en | output | 1 | Current enable bit |
| ctl_sel | output | 3 | Current threshold select |
| trig_rise_en | input | 1 | Pend on a rising detector edge (supply fell) |
| trig_fall_en | input | 1 | Pend on a falling detector edge (supply recovered) |
| pend_clr | input | 1 | Write-1-to-clear of the pending flag |
| det_below | output | 1 | Detector line and status: supply below threshold |
| edge_rise | output | 1 | One-cycle pulse on a detector rising edge |
| edge_fall | output | 1 | One-cycle pulse on a detector falling edge |
| irq_pend | output | 1 | Sticky interrupt pending flag |

## Verification
The bench builds the block with its defaults: eight entries from 2700 mV in 150 mV steps, 200 mV of hysteresis and a two-flop synchroniser. These values keep every falling and rising level between 2700 and 3950 mV, so readings swept over 2500 to 4100 mV cross every entry from both sides and stay inside the hysteresis band for whole cycles. With the two-flop depth, the three-edge latency, the deferral of an edge that coincides with a select write, and the set-over-clear race on the pending flag all land on cycles the bench can compute by hand.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int unsigned CODE_W = 12;

    typedef logic [CODE_W-1:0] mv_t;

    typedef struct packed {
        mv_t fall_mv;
        mv_t rise_mv;
    } trip_pair_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_UP   = 2'd1,
        EDGE_DOWN = 2'd2
    } edge_kind_t;

    function automatic trip_pair_t trip_for(int unsigned base_mv, int unsigned step_mv,
                                            int unsigned hyst_mv, int unsigned idx);
        trip_pair_t  t;
        int unsigned lvl;
        lvl       = base_mv + idx * step_mv;
        t.fall_mv = mv_t'(lvl);
        t.rise_mv = mv_t'(lvl + hyst_mv);
        return t;
    endfunction

    // fresh: judge against the falling level only, ignoring prior state
    function automatic logic trip_decide(mv_t code, trip_pair_t t, logic was_below, logic fresh);
        if (fresh || !was_below)
            return code < t.fall_mv;
        return code < t.rise_mv;
    endfunction

endpackage

// File: rtl/svm_trip_table.sv
module svm_trip_table import svm_pkg::*; #(
    parameter int unsigned N_LVL   = 8,
    parameter int unsigned BASE_MV = 2700,
    parameter int unsigned STEP_MV = 150,
    parameter int unsigned HYST_MV = 200,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [SEL_W-1:0] sel,
    output trip_pair_t       trip
);

    trip_pair_t tbl [N_LVL];

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        assign tbl[g] = trip_for(BASE_MV, STEP_MV, HYST_MV, g);
    end

    always_comb begin
        if (32'(sel) < N_LVL)
            trip = tbl[sel];
        else
            trip = tbl[N_LVL-1];
    end

endmodule

// File: rtl/svm_ctl_regs.sv
module svm_ctl_regs #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             en_wd,
    input  logic [SEL_W-1:0] sel_wd,
    output logic             en_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             reeval_q,
    output logic             blank
);

    logic sel_change;

    assign sel_change = wr && (sel_wd != sel_q);
    assign blank      = sel_change && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            sel_q    <= '0;
            reeval_q <= 1'b0;
        end else begin
            reeval_q <= sel_change || (wr && en_wd && !en_q);
            if (wr) begin
                en_q  <= en_wd;
                sel_q <= sel_wd;
            end
        end
    end

    // R2
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (en_q == $past(en_wd)) && (sel_q == $past(sel_wd)));

endmodule

// File: rtl/svm_hyst_cmp.sv
module svm_hyst_cmp import svm_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       reeval,
    input  mv_t        code,
    input  trip_pair_t trip,
    output logic       below_q
);

    always_ff @(posedge clk) begin
        if (rst || !en)
            below_q <= 1'b0;
        else
            below_q <= trip_decide(code, trip, below_q, reeval);
    end

    // R3
    fall_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !below_q && code < trip.fall_mv) |=> below_q);

    // R4
    hyst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !reeval && below_q && code < trip.rise_mv) |=> below_q);

    // R6
    fresh_eval_chk: assert property (@(posedge clk) disable iff (rst)
        (en && reeval) |=> (below_q == ($past(code) < $past(trip.fall_mv))));

endmodule

// File: rtl/svm_sync_edge.sv
module svm_sync_edge import svm_pkg::*; #(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       d,
    input  logic       blank,
    output logic       q,
    output edge_kind_t kind
);

    logic [STAGES-1:0] sh;
    logic              prev_q;

    assign q = sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh     <= '0;
            prev_q <= 1'b0;
        end else begin
            sh[0] <= d;
            for (int i = 1; i < STAGES; i++)
                sh[i] <= sh[i-1];
            if (!blank)
                prev_q <= q;
        end
    end

    always_comb begin
        kind = EDGE_NONE;
        if (!clr && !blank) begin
            if (q && !prev_q)
                kind = EDGE_UP;
            else if (!q && prev_q)
                kind = EDGE_DOWN;
        end
    end

    // R5
    clr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);

    // R7
    up_single_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EDGE_UP) |=> (kind != EDGE_UP));

    // R7
    down_single_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EDGE_DOWN) |=> (kind != EDGE_DOWN));

    // R7
    up_level_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EDGE_UP) |-> q);

endmodule

// File: rtl/svm_pend_flag.sv
module svm_pend_flag import svm_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  edge_kind_t kind,
    input  logic       rise_en,
    input  logic       fall_en,
    input  logic       clr,
    output logic       pend
);

    logic set;

    assign set = ((kind == EDGE_UP) && rise_en) || ((kind == EDGE_DOWN) && fall_en);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    // R10
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/svm_monitor.sv
module svm_monitor import svm_pkg::*; #(
    parameter int unsigned N_LVL       = 8,
    parameter int unsigned BASE_MV     = 2700,
    parameter int unsigned STEP_MV     = 150,
    parameter int unsigned HYST_MV     = 200,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SEL_W      = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] volt_mv,
    input  logic              ctl_wr,
    input  logic              ctl_en_wd,
    input  logic [SEL_W-1:0]  ctl_sel_wd,
    output logic              ctl_en,
    output logic [SEL_W-1:0]  ctl_sel,
    input  logic              trig_rise_en,
    input  logic              trig_fall_en,
    input  logic              pend_clr,
    output logic              det_below,
    output logic              edge_rise,
    output logic              edge_fall,
    output logic              irq_pend
);

    logic       reeval;
    logic       blank;
    logic       below_raw;
    trip_pair_t trip;
    edge_kind_t kind;

    svm_ctl_regs #(.SEL_W(SEL_W)) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctl_wr),
        .en_wd   (ctl_en_wd),
        .sel_wd  (ctl_sel_wd),
        .en_q    (ctl_en),
        .sel_q   (ctl_sel),
        .reeval_q(reeval),
        .blank   (blank)
    );

    svm_trip_table #(
        .N_LVL  (N_LVL),
        .BASE_MV(BASE_MV),
        .STEP_MV(STEP_MV),
        .HYST_MV(HYST_MV),
        .SEL_W  (SEL_W)
    ) tbl_i (
        .sel (ctl_sel),
        .trip(trip)
    );

    svm_hyst_cmp cmp_i (
        .clk    (clk),
        .rst    (rst),
        .en     (ctl_en),
        .reeval (reeval),
        .code   (volt_mv),
        .trip   (trip),
        .below_q(below_raw)
    );

    svm_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (!ctl_en),
        .d    (below_raw),
        .blank(blank),
        .q    (det_below),
        .kind (kind)
    );

    svm_pend_flag pend_i (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .rise_en(trig_rise_en),
        .fall_en(trig_fall_en),
        .clr    (pend_clr),
        .pend   (irq_pend)
    );

    assign edge_rise = (kind == EDGE_UP);
    assign edge_fall = (kind == EDGE_DOWN);

    // R8
    blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_en && (ctl_sel_wd != ctl_sel)) |-> !(edge_rise || edge_fall));

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !$past(ctl_en)) |-> (!det_below && !edge_rise && !edge_fall));

    // R7
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({edge_rise, edge_fall}));

endmodule

// File: tb/svm_monitor_tb.sv
module svm_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_LVL      = 8;
    localparam int BASE_MV    = 2700;
    localparam int STEP_MV    = 150;
    localparam int HYST_MV    = 200;
    localparam int SYNC       = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] volt_mv = 12'd3300;
    logic        ctl_wr = 1'b0;
    logic        ctl_en_wd = 1'b0;
    logic [2:0]  ctl_sel_wd = 3'd0;
    logic        ctl_en;
    logic [2:0]  ctl_sel;
    logic        trig_rise_en = 1'b0;
    logic        trig_fall_en = 1'b0;
    logic        pend_clr = 1'b0;
    logic        det_below, edge_rise, edge_fall, irq_pend;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svm_monitor #(
        .N_LVL(N_LVL), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV),
        .HYST_MV(HYST_MV), .SYNC_STAGES(SYNC)
    ) dut_i (
        .clk(clk), .rst(rst), .volt_mv(volt_mv),
        .ctl_wr(ctl_wr), .ctl_en_wd(ctl_en_wd), .ctl_sel_wd(ctl_sel_wd),
        .ctl_en(ctl_en), .ctl_sel(ctl_sel),
        .trig_rise_en(trig_rise_en), .trig_fall_en(trig_fall_en), .pend_clr(pend_clr),
        .det_below(det_below), .edge_rise(edge_rise), .edge_fall(edge_fall),
        .irq_pend(irq_pend)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input bit en, input int sel);
        ctl_wr     = 1'b1;
        ctl_en_wd  = en;
        ctl_sel_wd = 3'(sel);
        tick();
        ctl_wr = 1'b0;
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_en, m_reeval, m_low, m_prev, m_pend, live;
    int m_sel;
    bit pipe[$];

    initial begin
        for (int i = 0; i < SYNC; i++) pipe.push_back(1'b0);
    end

    function automatic bit m_det();
        return pipe[pipe.size()-1];
    endfunction

    function automatic bit m_blank();
        return ctl_wr && m_en && (int'(ctl_sel_wd) != m_sel);
    endfunction

    function automatic bit m_rp();
        return !m_blank() && m_en && m_det() && !m_prev;
    endfunction

    function automatic bit m_fp();
        return !m_blank() && m_en && !m_det() && m_prev;
    endfunction

    always @(posedge clk) begin
        bit rp, fp, bl, d, nlow;
        int fall;
        if (rst) begin
            m_en = 0; m_sel = 0; m_reeval = 0; m_low = 0; m_prev = 0; m_pend = 0;
            for (int i = 0; i < SYNC; i++) pipe[i] = 1'b0;
        end else begin
            rp = m_rp(); fp = m_fp(); bl = m_blank(); d = m_det();
            if ((rp && trig_rise_en) || (fp && trig_fall_en)) m_pend = 1;
            else if (pend_clr) m_pend = 0;
            fall = BASE_MV + m_sel * STEP_MV;
            if (!m_en) nlow = 0;
            else if (m_reeval || !m_low) nlow = int'(volt_mv) < fall;
            else nlow = int'(volt_mv) < fall + HYST_MV;
            if (!m_en) begin
                m_prev = 0;
                for (int i = 0; i < SYNC; i++) pipe[i] = 1'b0;
            end else begin
                if (!bl) m_prev = d;
                pipe.push_front(m_low);
                void'(pipe.pop_back());
            end
            m_low = nlow;
            m_reeval = ctl_wr && ((int'(ctl_sel_wd) != m_sel) || (ctl_en_wd && !m_en));
            if (ctl_wr) begin
                m_en  = ctl_en_wd;
                m_sel = int'(ctl_sel_wd);
            end
        end
        live = 1;
    end

    always @(negedge clk) begin
        if (live && !rst) begin
            check(det_below == m_det(), "R3", "model det_below", det_below, m_det());
            check(edge_rise == m_rp(), "R7", "model edge_rise", edge_rise, m_rp());
            check(edge_fall == m_fp(), "R7", "model edge_fall", edge_fall, m_fp());
            check(irq_pend == m_pend, "R9", "model irq_pend", irq_pend, m_pend);
            check(ctl_en == m_en, "R2", "model ctl_en", ctl_en, m_en);
            check(int'(ctl_sel) == m_sel, "R2", "model ctl_sel", ctl_sel, m_sel);
        end
    end

    // ---------------- directed stimulus ----------------
    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1
        check(!det_below && !irq_pend && !edge_rise && !edge_fall, "R1", "reset outputs",
              {det_below, irq_pend, edge_rise, edge_fall}, 0);
        check(!ctl_en && ctl_sel == 0, "R1", "reset control", {ctl_en, ctl_sel}, 0);

        // R2: enable with entry 2 (fall 3000, rise 3200)
        wr_ctl(1, 2);
        check(ctl_en && ctl_sel == 3'd2, "R2", "control readback", {ctl_en, ctl_sel}, 10);
        trig_rise_en = 1; trig_fall_en = 0;
        repeat (4) tick();
        check(!det_below, "R3", "above level", det_below, 0);

        // R3 / R7 / R9
        volt_mv = 12'd2950;
        tick(); tick();
        check(!det_below, "R3", "latency two edges", det_below, 0);
        tick();
        check(det_below && edge_rise, "R3", "set after third edge", {det_below, edge_rise}, 3);
        tick();
        check(!edge_rise && irq_pend, "R9", "rise pend set", {edge_rise, irq_pend}, 1);

        // R4: inside hysteresis band
        volt_mv = 12'd3150;
        repeat (5) tick();
        check(det_below, "R4", "hold in band", det_below, 1);

        // R10 clear
        pend_clr = 1; tick(); pend_clr = 0;
        check(!irq_pend, "R10", "pend cleared", irq_pend, 0);

        // R4 release at rise level, R9 disabled trigger
        volt_mv = 12'd3200;
        tick(); tick();
        check(det_below, "R4", "release latency", det_below, 1);
        tick();
        check(!det_below && edge_fall, "R4", "released", {det_below, edge_fall}, 1);
        tick();
        check(!irq_pend, "R9", "fall trigger off", irq_pend, 0);

        // R6: entry 3 (fall 3150) fresh evaluation
        volt_mv = 12'd3100;
        wr_ctl(1, 3);
        repeat (3) tick();
        check(det_below, "R6", "new level trips", det_below, 1);
        tick();
        // back to entry 2: fresh compare gives 0, hysteresis would give 1
        wr_ctl(1, 2);
        repeat (3) tick();
        check(!det_below && edge_fall, "R6", "no hysteresis memory", {det_below, edge_fall}, 1);

        // R8: write coincides with a rising edge
        volt_mv = 12'd2900;
        repeat (3) tick();
        check(edge_rise, "R8", "pulse present", edge_rise, 1);
        ctl_wr = 1; ctl_en_wd = 1; ctl_sel_wd = 3'd4;
        #1;
        check(!edge_rise, "R8", "blanked in write cycle", edge_rise, 0);
        tick();
        ctl_wr = 0;
        check(edge_rise, "R8", "deferred pulse", edge_rise, 1);
        tick();
        check(!edge_rise, "R8", "pulse single", edge_rise, 0);

        // R5: disable while below
        pend_clr = 1; tick(); pend_clr = 0;
        trig_fall_en = 1;
        wr_ctl(0, 4);
        tick();
        check(!det_below && !edge_fall, "R5", "disable drops quietly", {det_below, edge_fall}, 0);
        volt_mv = 12'd2500;
        repeat (6) tick();
        check(!det_below && !irq_pend, "R5", "stays idle", {det_below, irq_pend}, 0);

        // R10 set wins over clear
        wr_ctl(1, 4);
        repeat (3) tick();
        check(edge_rise, "R10", "rise before race", edge_rise, 1);
        pend_clr = 1; tick(); pend_clr = 0;
        check(irq_pend, "R10", "set beats clear", irq_pend, 1);

        // R9 fall trigger enabled
        pend_clr = 1; tick(); pend_clr = 0;
        check(!irq_pend, "R10", "cleared again", irq_pend, 0);
        volt_mv = 12'd3600;
        repeat (3) tick();
        check(edge_fall, "R9", "fall pulse", edge_fall, 1);
        tick();
        check(irq_pend, "R9", "fall pend set", irq_pend, 1);

        // sweep: model comparison over many patterns
        for (int i = 0; i < 1200; i++) begin
            if (i % 5 == 0) volt_mv = 12'(2500 + (i * 337) % 1600);
            ctl_wr       = (i % 60 == 7);
            ctl_en_wd    = ((i / 60) % 5 != 4);
            ctl_sel_wd   = 3'((i / 60) % 8);
            trig_rise_en = i[6];
            trig_fall_en = i[7];
            pend_clr     = (i % 23 == 0);
            tick();
        end
        ctl_wr = 0; pend_clr = 0;
        repeat (4) tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule